// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block tracks which memory blocks a data cache would hold, without storing any data. A requester presents a block-aligned address and an operation (load or store). The block looks up the set selected by the address and reports, one cycle later, whether the access hit or missed and whether a valid line had to be replaced. It also reports the simulated cycle cost of the access. The cost comes from a configurable cache access time and a main-memory model that transfers blocks as a burst of 8-byte units. Running totals of hits, misses and evictions are kept on dedicated outputs.

Set count, way count and block size are fixed when the block is built. The replacement policy (exact least-recently-used or pseudo-random), the write policy (write-through or write-back) and both latencies are static configuration inputs. They are expected to stay stable while requests are in flight. A store that misses always allocates the block first and then performs the store. The block accepts one request every two cycles. The reset input is asynchronous and active low, and its release is assumed to be synchronized to the clock outside the block. SETS, WAYS and BLOCK_BYTES must be powers of two, with SETS at least 2, WAYS from 1 to 64 and BLOCK_BYTES at least 8.

Top module: `cache_tag_ctrl`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `resp_valid` is high for exactly the following cycle, and `req_ready` is low during that cycle.
- R2: Each response raises exactly one of `resp_hit` and `resp_miss`. It is a hit when a valid line in the addressed set holds the address tag. The set index is address bits [log2(BLOCK_BYTES) +: log2(SETS)], and the tag is all bits above the index.
- R3: Let the block memory time be `cfg_mem_cycles + BLOCK_BYTES/8 - 1`. A load hit costs `cfg_cache_cycles`. A load miss costs `cfg_cache_cycles` plus the block memory time.
- R4: With `cfg_write_back` = 0, a store hit costs the cache time plus the block memory time. A store miss costs twice that sum.
- R5: With `cfg_write_back` = 1, a store hit costs only the cache time and marks the line dirty. A store miss costs the cache time plus the block memory time (the fetch), plus the cache time again (the store).
- R6: With `cfg_write_back` = 1, a miss that replaces a dirty line adds one block memory time to its cost. With write-through, a replacement adds no cycles.
- R7: A store miss allocates the block, so a later access to the same block hits.
- R8: A miss fills the lowest-numbered invalid way of the set without raising `resp_evict`. `resp_evict` is raised only when a miss replaces a valid line.
- R9: With `cfg_repl_lru` = 1, a miss in a full set replaces the way whose most recent access (hit or fill) is the oldest in that set.
- R10: With `cfg_repl_lru` = 0, a miss in a full set replaces a way picked by a free-running 16-bit LFSR taken modulo WAYS. The miss is flagged as an eviction, and the fetched block hits on the next access.
- R11: `hit_count`, `miss_count` and `evict_count` each rise by one for every response carrying the matching flag. They hold their value otherwise, and reset clears them to zero.
- R12: Reset invalidates every line, so an address cached before reset misses afterwards without an eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_repl_lru | input | 1 | 1 selects exact LRU replacement, 0 selects pseudo-random replacement |
| cfg_write_back | input | 1 | 1 selects write-back, 0 selects write-through |
| cfg_cache_cycles | input | CYC_W | Cache access time in cycles |
| cfg_mem_cycles | input | CYC_W | Cost of the first 8-byte memory unit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_store | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Block-aligned byte address |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Access hit |
| resp_miss | output | 1 | Access missed |
| resp_evict | output | 1 | A valid line was replaced |
| resp_cycles | output | CYC_W+3 | Simulated cost of the access |
| hit_count | output | CNT_W | Running hit total |
| miss_count | output | CNT_W | Running miss total |
| evict_count | output | CNT_W | Running eviction total |

## Verification
A first sweep loads and then stores every tag of a small tag range into every set. This separates cold fills (R8) from capacity evictions and write-through store costs. Directed sequences follow. One re-touches an old way before a conflicting miss, which tells true LRU apart from FIFO or age-blind choices. Another stores to every way of a set under write-back and then forces a miss, which separates the dirty write-back surcharge from a clean replacement. Long pseudo-random mixes of loads and stores over a few conflicting tags per set are compared against a timestamp-based reference model in both write policies. A random-replacement run checks only what is observable without predicting the LFSR: the eviction flag and the hit on the refetched block.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

  // Index width helper that never yields zero bits.
  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Outcome of one lookup.
  typedef struct packed {
    logic hit;
    logic miss;
    logic evict;
  } acc_flags_t;

endpackage

// File: rtl/cache_lru_ages.sv
// Per-set, per-way recency ranks. Rank 0 is the most recent access and rank
// WAYS-1 is the oldest. The ranks of one set always form a permutation.
module cache_lru_ages #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int SET_W = 3,
  parameter int WAY_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   touch_en,
  input  logic [SET_W-1:0]       touch_set,
  input  logic [WAY_W-1:0]       touch_way,
  input  logic [SET_W-1:0]       rd_set,
  output logic [WAYS*WAY_W-1:0]  rd_ages
);

  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] age_d [SETS][WAYS];
  logic [WAY_W-1:0] ref_age;

  assign ref_age = age_q[touch_set][touch_way];

  always_comb begin
    age_d = age_q;
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (touch_set == SET_W'(s)) begin
          if (touch_way == WAY_W'(w))
            age_d[s][w] = '0;
          else if (age_q[s][w] < ref_age)
            age_d[s][w] = age_q[s][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_rd
      assign rd_ages[g*WAY_W +: WAY_W] = age_q[rd_set][g];
    end
  endgenerate

endmodule

// File: rtl/cache_victim_sel.sv
// Chooses the way to fill on a miss: the lowest invalid way first, otherwise
// the oldest-ranked way (LRU) or the pseudo-random way.
module cache_victim_sel #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]        valid,
  input  logic [WAYS*WAY_W-1:0]  ages,
  input  logic [WAY_W-1:0]       rnd_way,
  input  logic                   use_lru,
  output logic [WAY_W-1:0]       victim
);

  logic found;

  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid[w] && !found) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      if (use_lru) begin
        for (int w = 0; w < WAYS; w++)
          if (ages[w*WAY_W +: WAY_W] == WAY_W'(WAYS-1))
            victim = WAY_W'(w);
      end else begin
        victim = rnd_way;
      end
    end
  end

endmodule

// File: rtl/cache_cost_calc.sv
// Simulated cycle cost of one access under the burst memory model.
module cache_cost_calc #(
  parameter int CYC_W  = 16,
  parameter int COST_W = 19,
  parameter int UNITS  = 2
) (
  input  logic              is_store,
  input  logic              is_hit,
  input  logic              write_back,
  input  logic              dirty_evict,
  input  logic [CYC_W-1:0]  cache_cyc,
  input  logic [CYC_W-1:0]  mem_cyc,
  output logic [COST_W-1:0] cost
);

  logic [COST_W-1:0] c_cache, c_blk, c_both, c_wb;

  always_comb begin
    c_cache = COST_W'(cache_cyc);
    c_blk   = COST_W'(mem_cyc) + COST_W'(UNITS - 1);
    c_both  = c_cache + c_blk;
    c_wb    = (write_back && dirty_evict && !is_hit) ? c_blk : '0;
    if (!is_store)
      cost = is_hit ? c_cache : c_both + c_wb;
    else if (write_back)
      cost = is_hit ? c_cache : c_both + c_cache + c_wb;
    else
      cost = is_hit ? c_both : c_both + c_both;
  end

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int SETS        = 8,
  parameter int WAYS        = 4,
  parameter int BLOCK_BYTES = 16,
  parameter int ADDR_W      = 32,
  parameter int CYC_W       = 16,
  parameter int CNT_W       = 32,
  localparam int COST_W     = CYC_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_repl_lru,
  input  logic              cfg_write_back,
  input  logic [CYC_W-1:0]  cfg_cache_cycles,
  input  logic [CYC_W-1:0]  cfg_mem_cycles,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic              resp_evict,
  output logic [COST_W-1:0] resp_cycles,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count
);

  localparam int SET_W = bits_for(SETS);
  localparam int WAY_W = bits_for(WAYS);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int UNITS = BLOCK_BYTES / 8;

  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  addr_unused_bits;
  logic              accept;

  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   valid_d [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [WAYS-1:0]   dirty_d [SETS];

  logic [WAYS-1:0]        match;
  logic                   hit;
  logic [WAY_W-1:0]       hit_way, victim, touch_way;
  logic [WAYS*WAY_W-1:0]  set_ages;
  logic [15:0]            lfsr_q, lfsr_d;
  logic [WAY_W-1:0]       rnd_way;
  logic                   evict, dirty_evict;
  logic [COST_W-1:0]      cost;
  acc_flags_t             flags_d, flags_q;
  logic                   resp_valid_q;
  logic [COST_W-1:0]      cost_q;
  logic [CNT_W-1:0]       hit_cnt_q, miss_cnt_q, ev_cnt_q;
  logic [CNT_W-1:0]       hit_cnt_d, miss_cnt_d, ev_cnt_d;

  assign set_idx          = req_addr[OFF_W +: SET_W];
  assign req_tag          = req_addr[ADDR_W-1 : OFF_W+SET_W];
  assign addr_unused_bits = req_addr[OFF_W-1:0];
  assign req_ready        = !resp_valid_q;
  assign accept           = req_valid && req_ready;

  // Tag compare across the addressed set.
  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = valid_q[set_idx][g] && (tag_q[set_idx][g] == req_tag);
    end
  endgenerate

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_way = WAY_W'(w);
  end
  assign hit = |match;

  // Free-running pseudo-random source.
  assign lfsr_d  = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  assign rnd_way = WAY_W'(lfsr_q % 16'(WAYS));

  cache_lru_ages #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_ages (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (accept),
    .touch_set (set_idx),
    .touch_way (touch_way),
    .rd_set    (set_idx),
    .rd_ages   (set_ages)
  );

  cache_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid   (valid_q[set_idx]),
    .ages    (set_ages),
    .rnd_way (rnd_way),
    .use_lru (cfg_repl_lru),
    .victim  (victim)
  );

  assign touch_way   = hit ? hit_way : victim;
  assign evict       = !hit && valid_q[set_idx][victim];
  assign dirty_evict = evict && dirty_q[set_idx][victim];

  cache_cost_calc #(.CYC_W(CYC_W), .COST_W(COST_W), .UNITS(UNITS)) u_cost (
    .is_store    (req_store),
    .is_hit      (hit),
    .write_back  (cfg_write_back),
    .dirty_evict (dirty_evict),
    .cache_cyc   (cfg_cache_cycles),
    .mem_cyc     (cfg_mem_cycles),
    .cost        (cost)
  );

  // Next state of line status.
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (!hit) begin
      valid_d[set_idx][victim] = 1'b1;
      dirty_d[set_idx][victim] = req_store && cfg_write_back;
    end else if (req_store && cfg_write_back) begin
      dirty_d[set_idx][hit_way] = 1'b1;
    end
  end

  always_comb begin
    flags_d.hit   = hit;
    flags_d.miss  = !hit;
    flags_d.evict = evict;
    hit_cnt_d     = hit_cnt_q  + CNT_W'(hit);
    miss_cnt_d    = miss_cnt_q + CNT_W'(!hit);
    ev_cnt_d      = ev_cnt_q   + CNT_W'(evict);
  end

  always_ff @(posedge clk) begin
    if (accept && !hit)
      tag_q[set_idx][victim] <= req_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
      lfsr_q       <= 16'hACE1;
      resp_valid_q <= 1'b0;
      flags_q      <= '0;
      cost_q       <= '0;
      hit_cnt_q    <= '0;
      miss_cnt_q   <= '0;
      ev_cnt_q     <= '0;
    end else begin
      lfsr_q       <= lfsr_d;
      resp_valid_q <= accept;
      if (accept) begin
        valid_q    <= valid_d;
        dirty_q    <= dirty_d;
        flags_q    <= flags_d;
        cost_q     <= cost;
        hit_cnt_q  <= hit_cnt_d;
        miss_cnt_q <= miss_cnt_d;
        ev_cnt_q   <= ev_cnt_d;
      end else if (resp_valid_q) begin
        flags_q    <= '0;
      end
    end
  end

  assign resp_valid  = resp_valid_q;
  assign resp_hit    = flags_q.hit;
  assign resp_miss   = flags_q.miss;
  assign resp_evict  = flags_q.evict;
  assign resp_cycles = cost_q;
  assign hit_count   = hit_cnt_q;
  assign miss_count  = miss_cnt_q;
  assign evict_count = ev_cnt_q;

endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk #(
  parameter int CYC_W  = 16,
  parameter int COST_W = 19,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_store,
  input logic [CYC_W-1:0]  cfg_cache_cycles,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              resp_miss,
  input logic              resp_evict,
  input logic [COST_W-1:0] resp_cycles,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count,
  input logic [CNT_W-1:0]  evict_count
);

  assert_resp_follows_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  assert_resp_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_hit_xor_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_hit ^ resp_miss));

  assert_load_hit_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit && !$past(req_store)) |->
      (resp_cycles == COST_W'($past(cfg_cache_cycles))));

  assert_evict_only_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_evict) |-> resp_miss);

  assert_hit_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> (hit_count == $past(hit_count) + 1'b1));

  assert_miss_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_miss) |-> (miss_count == $past(miss_count) + 1'b1));

  assert_counts_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> ($stable(hit_count) && $stable(miss_count) && $stable(evict_count)));

endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(.CYC_W(CYC_W), .COST_W(COST_W), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_store        (req_store),
  .cfg_cache_cycles (cfg_cache_cycles),
  .resp_valid       (resp_valid),
  .resp_hit         (resp_hit),
  .resp_miss        (resp_miss),
  .resp_evict       (resp_evict),
  .resp_cycles      (resp_cycles),
  .hit_count        (hit_count),
  .miss_count       (miss_count),
  .evict_count      (evict_count)
);

// File: tb/tb_cache_tag_ctrl.sv
`timescale 1ns/1ps
module tb_cache_tag_ctrl;

  localparam int SETS  = 4;
  localparam int WAYS  = 4;
  localparam int BB    = 16;
  localparam int AW    = 32;
  localparam int CW    = 16;
  localparam int NW    = 32;
  localparam int COSTW = CW + 3;
  localparam int UNITS = BB / 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_repl_lru, cfg_write_back;
  logic [CW-1:0] cfg_cache_cycles, cfg_mem_cycles;
  logic req_valid, req_ready, req_store;
  logic [AW-1:0] req_addr;
  logic resp_valid, resp_hit, resp_miss, resp_evict;
  logic [COSTW-1:0] resp_cycles;
  logic [NW-1:0] hit_count, miss_count, evict_count;

  always #10 clk = ~clk;

  cache_tag_ctrl #(.SETS(SETS), .WAYS(WAYS), .BLOCK_BYTES(BB), .ADDR_W(AW),
                   .CYC_W(CW), .CNT_W(NW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_repl_lru(cfg_repl_lru), .cfg_write_back(cfg_write_back),
    .cfg_cache_cycles(cfg_cache_cycles), .cfg_mem_cycles(cfg_mem_cycles),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_evict(resp_evict),
    .resp_cycles(resp_cycles), .hit_count(hit_count), .miss_count(miss_count),
    .evict_count(evict_count));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference model: per-line valid, dirty, tag and last-use timestamp.
  bit m_valid [SETS][WAYS];
  bit m_dirty [SETS][WAYS];
  int m_tag   [SETS][WAYS];
  int m_last  [SETS][WAYS];
  int m_now, m_hits, m_miss, m_ev;
  int unsigned lcg;

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 1'b0; m_dirty[s][w] = 1'b0; m_tag[s][w] = 0; m_last[s][w] = 0;
      end
    m_now = 1; m_hits = 0; m_miss = 0; m_ev = 0;
  endtask

  task automatic do_reset(input bit lru, input bit wb, input int cc, input int mc);
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_addr = '0;
    cfg_repl_lru = lru; cfg_write_back = wb;
    cfg_cache_cycles = CW'(cc); cfg_mem_cycles = CW'(mc);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(resp_valid == 1'b0 && req_ready == 1'b1, "R1", "reset handshake state",
          {resp_valid, req_ready}, 1);
    check(hit_count == 0 && miss_count == 0 && evict_count == 0, "R11",
          "reset counter sum", int'(hit_count + miss_count + evict_count), 0);
    rst_n = 1'b1;
    model_reset();
  endtask

  // Drive one request and return what the block reported.
  task automatic dut_access(input bit st, input int set, input int tag,
                            output bit h, output bit e, output int cost);
    @(negedge clk);
    req_valid = 1'b1; req_store = st;
    req_addr  = (AW'(tag) << 6) | (AW'(set) << 4);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(resp_valid == 1'b1 && req_ready == 1'b0, "R1", "response strobe/ready",
          {resp_valid, req_ready}, 2);
    check(resp_hit != resp_miss, "R2", "hit/miss exclusivity", {resp_hit, resp_miss}, 1);
    h = resp_hit; e = resp_evict; cost = int'(resp_cycles);
    @(posedge clk);
    @(negedge clk);
    check(resp_valid == 1'b0, "R1", "strobe width", resp_valid, 0);
  endtask

  task automatic model_access(input bit st, input int set, input int tag,
                              output bit h, output bit e, output bit vd, output int cost);
    int way, cc, blk;
    bit wb;
    wb = cfg_write_back; cc = int'(cfg_cache_cycles); blk = int'(cfg_mem_cycles) + UNITS - 1;
    way = -1; h = 1'b0; e = 1'b0; vd = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (m_valid[set][w] && m_tag[set][w] == tag) begin way = w; h = 1'b1; end
    if (h) begin
      if (st && wb) m_dirty[set][way] = 1'b1;
    end else begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (!m_valid[set][w]) way = w;
      if (way < 0) begin
        way = 0;
        for (int w = 1; w < WAYS; w++)
          if (m_last[set][w] < m_last[set][way]) way = w;
        e = 1'b1;
        vd = wb && m_dirty[set][way];
      end
      m_valid[set][way] = 1'b1; m_tag[set][way] = tag; m_dirty[set][way] = st && wb;
    end
    m_last[set][way] = m_now; m_now++;
    if (!st)     cost = h ? cc : cc + blk + (vd ? blk : 0);
    else if (wb) cost = h ? cc : cc + blk + cc + (vd ? blk : 0);
    else         cost = h ? cc + blk : 2 * (cc + blk);
    if (h) m_hits++; else m_miss++;
    if (e) m_ev++;
  endtask

  task automatic check_access(input bit st, input int set, input int tag, input string tagreq,
                              output bit got_h);
    bit dh, de, mh, me, mvd;
    int dc, mc;
    string req;
    model_access(st, set, tag, mh, me, mvd, mc);
    dut_access(st, set, tag, dh, de, dc);
    if (tagreq != "")   req = tagreq;
    else if (mvd)       req = "R6";
    else if (me)        req = "R8";
    else if (!st)       req = "R3";
    else if (!mh)       req = "R7";
    else                req = cfg_write_back ? "R5" : "R4";
    check(dh == mh && de == me, req, $sformatf("set %0d tag %0d hit/evict", set, tag),
          {dh, de}, {mh, me});
    check(dc == mc, req, $sformatf("set %0d tag %0d store=%0d cost", set, tag, st), dc, mc);
    got_h = dh;
  endtask

  task automatic check_counts(input string phase);
    check(int'(hit_count) == m_hits, "R11", {phase, " hit_count"}, int'(hit_count), m_hits);
    check(int'(miss_count) == m_miss, "R11", {phase, " miss_count"}, int'(miss_count), m_miss);
    check(int'(evict_count) == m_ev, "R11", {phase, " evict_count"}, int'(evict_count), m_ev);
  endtask

  task automatic lcg_mix(input int n);
    bit h;
    for (int i = 0; i < n; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      check_access(lcg[20], int'(lcg[17:16]), int'(lcg[26:24]) % 6, "", h);
    end
  endtask

  initial begin : main
    bit h, e;
    int c;
    lcg = 32'h1234_5678;
    // Phase A: write-through, LRU.
    do_reset(1'b1, 1'b0, 13, 230);
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < 6; t++) check_access(1'b0, s, t, "", h);
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < 6; t++) check_access(1'b1, s, t, "", h);
    // R9: refresh tag 10 so tag 11 becomes the oldest.
    for (int t = 10; t < 14; t++) check_access(1'b0, 0, t, "", h);
    check_access(1'b0, 0, 10, "R9", h);
    check_access(1'b0, 0, 14, "R9", h);
    check_access(1'b0, 0, 12, "R9", h);
    check(h == 1'b1, "R9", "tag 12 still resident", h, 1);
    check_access(1'b0, 0, 11, "R9", h);
    check(h == 1'b0, "R9", "oldest tag 11 replaced", h, 0);
    lcg_mix(200);
    check_counts("write-through");

    // Phase B: write-back, LRU, other latencies.
    do_reset(1'b1, 1'b1, 5, 100);
    check_access(1'b0, 0, 10, "R12", h);
    check(h == 1'b0, "R12", "line invalid after reset", h, 0);
    check_access(1'b1, 1, 3, "R7", h);
    check_access(1'b0, 1, 3, "R7", h);
    check(h == 1'b1, "R7", "allocated by store miss", h, 1);
    check_access(1'b1, 1, 3, "R5", h);
    for (int t = 0; t < 4; t++) check_access(1'b1, 2, t, "", h);
    check_access(1'b0, 2, 4, "R6", h);
    check_access(1'b1, 2, 5, "R6", h);
    for (int t = 0; t < 4; t++) check_access(1'b0, 3, t, "", h);
    check_access(1'b0, 3, 4, "R6", h);
    lcg_mix(300);
    check_counts("write-back");

    // Phase C: random replacement, write-through.
    do_reset(1'b0, 1'b0, 13, 230);
    for (int t = 0; t < 4; t++) check_access(1'b0, 0, t, "R8", h);
    dut_access(1'b0, 0, 9, h, e, c);
    check(h == 1'b0 && e == 1'b1, "R10", "random full-set miss evicts", {h, e}, 1);
    check(c == 13 + 230 + UNITS - 1, "R10", "random miss cost", c, 13 + 230 + UNITS - 1);
    dut_access(1'b0, 0, 9, h, e, c);
    check(h == 1'b1 && e == 1'b0, "R10", "refetched block hits", {h, e}, 2);
    check(int'(evict_count) == 1, "R11", "single random eviction", int'(evict_count), 1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule